// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is a write-only serial slave. It lets a host set a few configuration bits over three wires: an active-low enable, a serial clock and a serial data line. The host drops the enable, then shifts 16-bit words in, most significant bit first. A bit is taken on each rising edge of the serial clock. In every word, the top four bits select a register and the lower twelve bits carry its data.

One enable window may carry several complete words back to back. Each word is committed on its own as soon as its sixteenth bit arrives. If the enable is released partway through a word, the bits received so far are thrown away.

The three serial inputs are asynchronous to the block's own faster system clock. Each passes through a two-flop synchroniser. Serial clock edges are then found by comparing successive synchronised samples.

The register file holds two outputs:
- a two-bit test-pattern selector at address 4'b1110;
- a power-down flag at address 4'b1111.

Both reset to zero.

Top module: `cfg_serial_port`

## Requirements
- R1: A word is 16 bits, shifted MSB first. Word bits [15:12] are the address and bits [11:0] are data D11..D0.
- R2: A committed word with address 4'b1110 loads `test_pat` from data bits D10 (to `test_pat[1]`) and D9 (to `test_pat[0]`). It leaves `pwr_down` unchanged.
- R3: A committed word with address 4'b1111 loads `pwr_down` from data bit D11, where 1 means low power. It leaves `test_pat` unchanged.
- R4: A committed word with any other address changes neither output.
- R5: A single enable window can carry several consecutive 16-bit words. Each one is committed separately.
- R6: If enable is released before 16 bits have been taken, the partial word is discarded. The next window starts again from bit 15.
- R7: An active-low reset clears `test_pat` to 2'b00 and `pwr_down` to 0.
- R8: Serial clock edges that occur while enable is high have no effect.
- R9: If the synchronised enable release and the 16th rising serial-clock edge are seen in the same system cycle, the word is discarded.
- R10: The outputs update on the third system clock edge after the 16th serial-clock rise. This latency comes from two synchroniser flops and one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Serial enable, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, data taken on rising edges |
| ser_dat | input | 1 | Serial data, MSB first |
| test_pat | output | 2 | Test-pattern select field |
| pwr_down | output | 1 | Power-down flag, 1 = low power |

## Verification
Two events can land in the same system cycle: the commit of a word on its 16th serial edge, and the end of the enable window. To provoke this, the bench raises the serial clock and releases the enable in the same system cycle, so both pass through the synchronisers together. The test is judged by checking that the power-down flag keeps its old value, because enable release takes precedence. A second directed case counts system edges after the final serial rise, to pin down the exact cycle in which a commit becomes visible.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 16,
  parameter int ADDR_BITS   = 4,
  parameter int TP_LSB      = 9,
  parameter int PD_BIT      = 11,
  parameter logic [ADDR_BITS-1:0] TP_ADDR = 4'hE,
  parameter logic [ADDR_BITS-1:0] PD_ADDR = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_en_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic [1:0] test_pat,
  output logic       pwr_down
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [SYNC_STAGES-1:0] clk_sync, en_sync, dat_sync;
  logic                   sclk_q;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_BITS-2:0]   shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sync <= '0;
      en_sync  <= '1;
      dat_sync <= '0;
      sclk_q   <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      en_sync  <= {en_sync[SYNC_STAGES-2:0], ser_en_n};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_dat};
      sclk_q   <= clk_sync[SYNC_STAGES-1];
    end

  wire sclk_s  = clk_sync[SYNC_STAGES-1];
  wire dat_s   = dat_sync[SYNC_STAGES-1];
  wire en_act  = ~en_sync[SYNC_STAGES-1];
  wire bit_stb = en_act & sclk_s & ~sclk_q;
  wire commit  = bit_stb && (bit_cnt == LAST);

  wire [WORD_BITS-1:0] word = {shreg, dat_s};
  wire [ADDR_BITS-1:0] addr = word[WORD_BITS-1 -: ADDR_BITS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!en_act) begin
      bit_cnt <= '0;
    end else if (bit_stb) begin
      bit_cnt <= commit ? '0 : bit_cnt + 1'b1;
      shreg   <= {shreg[WORD_BITS-3:0], dat_s};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      test_pat <= 2'b00;
      pwr_down <= 1'b0;
    end else if (commit) begin
      if (addr == TP_ADDR) test_pat <= word[TP_LSB +: 2];
      if (addr == PD_ADDR) pwr_down <= word[PD_BIT];
    end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic        en_act,
  input logic [15:0] word,
  input logic [3:0]  bit_cnt,
  input logic [1:0]  test_pat,
  input logic        pwr_down
);
  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (test_pat == 2'b00 && !pwr_down));

  assert_hold_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(test_pat) && $stable(pwr_down)));

  assert_tp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:12] == 4'hE) |=> (test_pat == $past(word[10:9]) && $stable(pwr_down)));

  assert_pd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:12] == 4'hF) |=> (pwr_down == $past(word[11]) && $stable(test_pat)));

  assert_other_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:13] != 3'b111) |=> ($stable(test_pat) && $stable(pwr_down)));

  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> (bit_cnt == 4'd0));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (bit_cnt == 4'd0));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .en_act(en_act),
  .word(word), .bit_cnt(bit_cnt), .test_pat(test_pat), .pwr_down(pwr_down)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [1:0] test_pat;
  logic pwr_down;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  localparam int HALF = 4;

  always #10 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .test_pat(test_pat), .pwr_down(pwr_down));

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic open_win();
    ser_en_n = 1'b0;
    idle(HALF);
  endtask

  task automatic close_win();
    ser_clk = 1'b0;
    ser_en_n = 1'b1;
    idle(8);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0;
      ser_dat = w[15-i];
      idle(HALF);
      ser_clk = 1'b1;
      idle(HALF);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    open_win();
    send_bits(w, 16);
    close_win();
  endtask

  task automatic t_reset();
    chk("R7 test_pat after reset", test_pat, 0);
    chk("R7 pwr_down after reset", pwr_down, 0);
  endtask

  task automatic t_test_pattern();
    write_word(16'hE400);
    chk("R1 R2 test_pat from D10:D9", test_pat, 2);
    chk("R2 pwr_down untouched", pwr_down, 0);
    write_word(16'hEE00);
    chk("R2 test_pat both bits", test_pat, 3);
  endtask

  task automatic t_power_down();
    write_word(16'hF800);
    chk("R3 pwr_down set", pwr_down, 1);
    chk("R3 test_pat untouched", test_pat, 3);
  endtask

  task automatic t_ignored();
    write_word(16'hD7FF);
    write_word(16'h0FFF);
    chk("R4 test_pat after foreign address", test_pat, 3);
    chk("R4 pwr_down after foreign address", pwr_down, 1);
  endtask

  task automatic t_multi();
    open_win();
    send_bits(16'hE200, 16);
    send_bits(16'hF000, 16);
    close_win();
    chk("R5 first word of window", test_pat, 1);
    chk("R5 second word of window", pwr_down, 0);
  endtask

  task automatic t_partial();
    open_win();
    send_bits(16'hF800, 10);
    close_win();
    chk("R6 partial word dropped", pwr_down, 0);
    write_word(16'hE600);
    chk("R6 realigned after partial", test_pat, 3);
  endtask

  task automatic t_disabled_clock();
    ser_en_n = 1'b1;
    send_bits(16'hF800, 16);
    ser_clk = 1'b0;
    idle(8);
    chk("R8 edges with enable high", pwr_down, 0);
    chk("R8 test_pat with enable high", test_pat, 3);
  endtask

  task automatic t_latency();
    open_win();
    send_bits(16'hE200, 15);
    ser_clk = 1'b0;
    ser_dat = 1'b0;
    idle(HALF);
    ser_clk = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 old value after 1 edge", test_pat, 3);
    @(posedge clk); @(negedge clk);
    chk("R10 old value after 2 edges", test_pat, 3);
    @(posedge clk); @(negedge clk);
    chk("R10 new value after 3 edges", test_pat, 1);
    close_win();
  endtask

  task automatic t_race();
    open_win();
    send_bits(16'hF800, 15);
    ser_clk = 1'b0;
    ser_dat = 1'b0;
    idle(HALF);
    ser_clk = 1'b1;
    ser_en_n = 1'b1;
    idle(8);
    ser_clk = 1'b0;
    idle(4);
    chk("R9 release beats 16th edge", pwr_down, 0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_test_pattern();
    t_power_down();
    t_ignored();
    t_multi();
    t_partial();
    t_disabled_clock();
    t_latency();
    t_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule